// File: doc/BRIEF.md
# Synchronous UART Transmitter with Clock Output

This block sends bytes as ordinary asynchronous frames: a low start bit, eight data bits with the least significant first, and a high stop bit. Each bit lasts a fixed number of oversampling ticks. Alongside the data line it drives a master serial clock, so that a partner device can capture the data synchronously instead of recovering timing from the line. The clock toggles only while data bits are on the line. It rests at its idle level during idle time, the start bit, the stop bit and break frames. Clock polarity, clock phase and whether the final data bit gets a clock pulse are set through configuration inputs. These settings are latched when a frame is accepted.

Bytes enter through a valid/ready handshake, and a separate request sends a break frame. A small receiver shares the generated clock. It samples its input line on the capture edge chosen by polarity and phase, with no oversampling. It presents the byte with a one-cycle valid pulse once the data bits of the frame are over. When the last-bit clock is switched off, the receiver sees only seven capture edges and the top data bit reads as zero.

Top module: `ckd_uart`

## Requirements
- R1: After a synchronous reset, `tx` is 1, `busy` is 0, `rx_valid` is 0 and `sclk` equals `cfg_cpol`.
- R2: `in_ready` is high exactly when `en_tx` is 1, `busy` is 0 and `brk_req` is 0. A byte is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` stays high for exactly 160 ticks (10 bits of 16 ticks), counting only ticks after the accepting edge.
- R3: `tx` carries bit 0 of a frame low (start), bits 1 to 8 equal to data bits 0 to 7, and bit 9 high (stop). Bit b of a frame spans tick counts 16*b to 16*b+15 after acceptance, and `tx`, `sclk` and `busy` change only on edges where `tick` is 1.
- R4: `sclk` equals the polarity value (0 or 1 = idle low or idle high) while idle, during the start bit and during the stop bit.
- R5: During a clocked data bit at sub-tick s (0..15), `sclk` is the inverse of the idle level when phase is 0 and s is 8 or more, or when phase is 1 and s is below 8. Otherwise it is at the idle level. The mid-bit edge is therefore the capture edge in both phases.
- R6: When `cfg_last_clk` is 0, `sclk` stays at the idle level for the whole of data bit 7. When it is 1, that bit is clocked like the others.
- R7: Polarity, phase and last-bit-clock settings are captured when a frame is accepted. Changing the inputs during a frame has no effect on that frame. While idle, `sclk` follows the current `cfg_cpol`.
- R8: When `brk_req` is 1, `en_tx` is 1 and `busy` is 0, a break frame starts and takes priority over a pending byte. `tx` is low for all 160 ticks, `busy` is high, `sclk` stays idle and no `rx_valid` pulse follows.
- R9: While `en_tx` is 0, no frame starts, `in_ready` is 0, `tx` stays 1 and `sclk` stays idle.
- R10: The receiver shifts in `rx` on each capture edge of `sclk`, least significant bit first. In the cycle after the edge whose tick ends data bit 7 (tick count 144), it pulses `rx_valid` for one cycle with `rx_data` holding the sampled byte.
- R11: A frame sent with `cfg_last_clk` at 0 yields `rx_data` bits 6:0 equal to the seven sampled bits and bit 7 equal to 0.
- R12: `rx_valid` is never high in two consecutive cycles and only arises from data frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Oversampling enable, 16 per bit |
| en_tx | input | 1 | Transmitter enable |
| cfg_cpol | input | 1 | Clock idle level |
| cfg_cpha | input | 1 | Clock phase: 0 first edge mid-bit, 1 first edge at bit start |
| cfg_last_clk | input | 1 | 1 = clock pulse for data bit 7 |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be taken this cycle |
| brk_req | input | 1 | Request a break frame |
| tx | output | 1 | Serial data out |
| sclk | output | 1 | Serial clock out |
| busy | output | 1 | Frame in progress |
| rx | input | 1 | Serial data in, sampled on the capture edge |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |

## Verification
The bench sweeps all eight combinations of polarity, phase and last-bit clock over several byte patterns, at two tick rates. A tick-count model predicts every output in every cycle. A design that pulsed the clock during start or stop bits, put its edges in the wrong half of a bit, or clocked bit 7 regardless of the setting would show a wrong `sclk` level at a precise sub-tick. The receiver runs on both a straight and an inverted loopback, so a receiver that sampled on the launch edge, or that mishandled the seven-edge frame, returns the wrong byte. A mismatch in `rx_valid` timing also shows up. Further runs cover held-valid back-to-back frames, a break competing with a byte, a disabled transmitter and settings changed mid-frame. These expose lost or extra cycles between frames, a broken priority, and settings that were not latched.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_START = 2'd1,
        PH_DATA  = 2'd2,
        PH_STOP  = 2'd3
    } ckd_phase_e;

    typedef struct packed {
        logic cpol;
        logic cpha;
        logic last_clk;
    } ckd_cfg_t;

    // Clock level: idle unless a pulse is enabled for this half of the bit.
    function automatic logic ckd_sclk_level(ckd_cfg_t c, logic pulse_on, logic late_half);
        logic active;
        active = c.cpha ? ~late_half : late_half;
        return c.cpol ^ (pulse_on & active);
    endfunction

    // Level sclk takes right after the capture edge.
    function automatic logic ckd_cap_level(logic cpol, logic cpha);
        return cpol ^ ~cpha;
    endfunction

endpackage

// File: rtl/ckd_tx_frame.sv
module ckd_tx_frame
    import ckd_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  ckd_cfg_t      cfg,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    input  logic          brk_req,
    output logic          in_ready,
    output logic          tx,
    output logic          sclk,
    output logic          busy,
    output ckd_cfg_t      cfg_q,
    output logic          frm_start,
    output logic          frm_end
);
    localparam int SW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam int BW = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [SW-1:0] SUB_LAST = SW'(OVS - 1);
    localparam logic [SW-1:0] SUB_HALF = SW'(OVS / 2);
    localparam logic [BW-1:0] BIT_LAST = BW'(DW - 1);

    ckd_phase_e    phase;
    logic [SW-1:0] sub;
    logic [BW-1:0] bitn;
    logic [DW-1:0] shreg;
    logic          brk;

    logic take_brk, take_byte, bit_done, pulse_on;
    ckd_cfg_t cfg_now;

    assign busy      = (phase != PH_IDLE);
    assign in_ready  = en & ~busy & ~brk_req;
    assign take_brk  = en & ~busy & brk_req;
    assign take_byte = in_valid & in_ready;
    assign bit_done  = tick & (sub == SUB_LAST);
    assign frm_start = take_byte;
    assign frm_end   = bit_done & (phase == PH_DATA) & (bitn == BIT_LAST) & ~brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            sub   <= '0;
            bitn  <= '0;
            shreg <= '0;
            brk   <= 1'b0;
            cfg_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (take_brk || take_byte) begin
                        phase <= PH_START;
                        sub   <= '0;
                        bitn  <= '0;
                        brk   <= take_brk;
                        shreg <= take_brk ? '0 : in_data;
                        cfg_q <= cfg;
                    end
                end
                default: begin
                    if (tick) begin
                        sub <= bit_done ? '0 : sub + SW'(1);
                    end
                    if (bit_done) begin
                        unique case (phase)
                            PH_START: phase <= PH_DATA;
                            PH_DATA: begin
                                shreg <= shreg >> 1;
                                if (bitn == BIT_LAST) begin
                                    phase <= PH_STOP;
                                end else begin
                                    bitn <= bitn + BW'(1);
                                end
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end
                end
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            PH_IDLE:  tx = 1'b1;
            PH_START: tx = 1'b0;
            PH_DATA:  tx = ~brk & shreg[0];
            default:  tx = ~brk;
        endcase
    end

    assign pulse_on = (phase == PH_DATA) & ~brk & ((bitn != BIT_LAST) | cfg_q.last_clk);
    assign cfg_now  = busy ? cfg_q : cfg;
    assign sclk     = ckd_sclk_level(cfg_now, pulse_on, sub >= SUB_HALF);

endmodule

// File: rtl/ckd_rx_edge.sv
module ckd_rx_edge
    import ckd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx,
    input  logic          sclk,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          frm_start,
    input  logic          frm_end,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);

    logic          sclk_q, armed, cap_edge;
    logic [DW-1:0] shreg, aligned;
    logic [CW-1:0] cnt;

    assign cap_edge = armed & (sclk != sclk_q) & (sclk == ckd_cap_level(cpol, cpha));
    assign aligned  = shreg >> (FULL - cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            armed    <= 1'b0;
            shreg    <= '0;
            cnt      <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            sclk_q   <= sclk;
            rx_valid <= 1'b0;
            if (frm_start) begin
                armed <= 1'b1;
                shreg <= '0;
                cnt   <= '0;
            end else begin
                if (cap_edge) begin
                    shreg <= {rx, shreg[DW-1:1]};
                    cnt   <= cnt + CW'(1);
                end
                if (frm_end) begin
                    armed    <= 1'b0;
                    rx_valid <= 1'b1;
                    rx_data  <= aligned;
                end
            end
        end
    end

endmodule

// File: rtl/ckd_uart.sv
module ckd_uart
    import ckd_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en_tx,
    input  logic          cfg_cpol,
    input  logic          cfg_cpha,
    input  logic          cfg_last_clk,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    input  logic          brk_req,
    output logic          tx,
    output logic          sclk,
    output logic          busy,
    input  logic          rx,
    output logic [DW-1:0] rx_data,
    output logic          rx_valid
);
    ckd_cfg_t cfg_in, cfg_lat;
    logic     frm_start, frm_end;

    assign cfg_in = '{cpol: cfg_cpol, cpha: cfg_cpha, last_clk: cfg_last_clk};

    ckd_tx_frame #(.OVS(OVS), .DW(DW)) u_tx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (en_tx),
        .cfg      (cfg_in),
        .in_valid (in_valid),
        .in_data  (in_data),
        .brk_req  (brk_req),
        .in_ready (in_ready),
        .tx       (tx),
        .sclk     (sclk),
        .busy     (busy),
        .cfg_q    (cfg_lat),
        .frm_start(frm_start),
        .frm_end  (frm_end)
    );

    ckd_rx_edge #(.DW(DW)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .rx       (rx),
        .sclk     (sclk),
        .cpol     (cfg_lat.cpol),
        .cpha     (cfg_lat.cpha),
        .frm_start(frm_start),
        .frm_end  (frm_end),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

endmodule

// File: rtl/ckd_uart_chk.sv
module ckd_uart_chk (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic en_tx,
    input logic cfg_cpol,
    input logic in_valid,
    input logic in_ready,
    input logic brk_req,
    input logic tx,
    input logic sclk,
    input logic busy,
    input logic rx_valid
);
    // R4
    idle_line_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tx && sclk == cfg_cpol));

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> (busy && !tx));

    // R8
    brk_start_chk: assert property (@(posedge clk) disable iff (rst)
        (brk_req && en_tx && !busy) |=> (busy && !tx));

    // R3
    tick_paced_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> ($stable(tx) && $stable(sclk) && busy));

    // R3
    end_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(tick));

    // R12
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    // R10
    valid_in_stop_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (busy && tx));

endmodule

bind ckd_uart ckd_uart_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .en_tx    (en_tx),
    .cfg_cpol (cfg_cpol),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .brk_req  (brk_req),
    .tx       (tx),
    .sclk     (sclk),
    .busy     (busy),
    .rx_valid (rx_valid)
);

// File: tb/ckd_uart_tb.sv
module ckd_uart_tb;
    localparam int OVS = 16;
    localparam int DW  = 8;
    localparam int FRM = 10 * OVS;
    localparam int END_DATA = 9 * OVS;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_d = 1'b1, tick_d = 1'b0, en_d = 1'b1;
    logic cpol_d = 1'b0, cpha_d = 1'b0, lc_d = 1'b1;
    logic vld_d = 1'b0, brk_d = 1'b0, inv_d = 1'b0;
    logic [7:0] data_d = 8'h00;

    logic in_ready, tx, sclk, busy, rx_valid, rx_line;
    logic [7:0] rx_data;

    assign rx_line = inv_d ? ~tx : tx;

    ckd_uart #(.OVS(OVS), .DW(DW)) u_dut (
        .clk(clk), .rst(rst_d), .tick(tick_d), .en_tx(en_d),
        .cfg_cpol(cpol_d), .cfg_cpha(cpha_d), .cfg_last_clk(lc_d),
        .in_valid(vld_d), .in_data(data_d), .in_ready(in_ready),
        .brk_req(brk_d), .tx(tx), .sclk(sclk), .busy(busy),
        .rx(rx_line), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    int nchk = 0, nfail = 0;
    bit done = 0;
    int tdiv = 1, tcnt = 0;

    bit act = 0, mbrk = 0, mcpol = 0, mcpha = 0, mlc = 0, minv = 0;
    int k = 0;
    logic [7:0] mbyte = 8'h00;

    task automatic chk(string tag, logic [7:0] actv, logic [7:0] expv);
        nchk++;
        if (actv !== expv) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, actv, expv, $time);
        end
    endtask

    task automatic step();
        bit exp_rv;
        int b, s;
        logic etx, esc;
        logic [7:0] erx;
        string stag, ttag;
        @(negedge clk);
        exp_rv = 0;
        if (rst_d) begin
            act = 0; k = 0;
        end else if (!act && en_d && brk_d) begin
            act = 1; k = 0; mbrk = 1;
            mcpol = cpol_d; mcpha = cpha_d; mlc = lc_d; minv = inv_d;
        end else if (!act && en_d && vld_d) begin
            act = 1; k = 0; mbrk = 0; mbyte = data_d;
            mcpol = cpol_d; mcpha = cpha_d; mlc = lc_d; minv = inv_d;
        end else if (act && tick_d) begin
            k++;
            if (k == END_DATA && !mbrk) exp_rv = 1;
            if (k == FRM) act = 0;
        end
        b = k / OVS;
        s = k % OVS;
        if (!act) begin
            etx = 1'b1; esc = cpol_d;
        end else if (mbrk) begin
            etx = 1'b0; esc = mcpol;
        end else begin
            etx = (b == 0) ? 1'b0 : (b <= 8) ? mbyte[b-1] : 1'b1;
            if (b >= 1 && b <= 8 && (b <= 7 || mlc))
                esc = mcpol ^ (mcpha ? (s < 8) : (s >= 8));
            else
                esc = mcpol;
        end
        ttag = rst_d ? "R1" : (act && mbrk) ? "R8" : !en_d ? "R9" : "R3";
        if (rst_d) stag = "R1";
        else if (!act) stag = en_d ? "R4" : "R9";
        else if (mbrk) stag = "R8";
        else if (mcpol != cpol_d || mcpha != cpha_d || mlc != lc_d) stag = "R7";
        else if (b == 8 && !mlc) stag = "R6";
        else if (b >= 1 && b <= 8) stag = "R5";
        else stag = "R4";
        chk(ttag, {7'd0, tx}, {7'd0, etx});
        chk(stag, {7'd0, sclk}, {7'd0, esc});
        chk(rst_d ? "R1" : "R2", {7'd0, busy}, {7'd0, act});
        chk(en_d ? "R2" : "R9", {7'd0, in_ready}, {7'd0, (en_d && !act && !brk_d)});
        chk(rst_d ? "R1" : "R12", {7'd0, rx_valid}, {7'd0, exp_rv});
        if (exp_rv) begin
            erx = minv ? ~mbyte : mbyte;
            if (!mlc) erx[7] = 1'b0;
            chk(mlc ? "R10" : "R11", rx_data, erx);
        end
        tcnt = (tcnt + 1) % tdiv;
        tick_d = (tcnt == 0);
    endtask

    task automatic wait_idle();
        while (act) step();
        step();
    endtask

    task automatic send(logic [7:0] d, logic inv);
        while (act) step();
        inv_d = inv;
        data_d = d;
        vld_d = 1'b1;
        step();
        vld_d = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        logic [7:0] pats [6];
        pats = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01};
        repeat (4) step();
        rst_d = 1'b0;
        step();

        // R9: disabled transmitter ignores a pending byte and a break
        en_d = 1'b0; vld_d = 1'b1; data_d = 8'h3C;
        repeat (30) step();
        brk_d = 1'b1;
        repeat (10) step();
        brk_d = 1'b0; vld_d = 1'b0; en_d = 1'b1;
        step();

        // R3..R6, R10, R11: full configuration sweep at two tick rates
        for (int r = 0; r < 2; r++) begin
            tdiv = (r == 0) ? 1 : 3;
            for (int c = 0; c < 8; c++) begin
                cpol_d = c[0]; cpha_d = c[1]; lc_d = c[2];
                step();
                for (int p = 0; p < 6; p++) begin
                    send(pats[p], p[0]);
                    wait_idle();
                end
            end
        end

        // R2: valid held high gives back-to-back frames
        tdiv = 1; cpol_d = 1'b1; cpha_d = 1'b0; lc_d = 1'b1;
        inv_d = 1'b0; data_d = 8'h96; vld_d = 1'b1;
        repeat (3 * FRM + 5) step();
        vld_d = 1'b0;
        wait_idle();

        // R8: break wins over a byte offered in the same cycle
        cpol_d = 1'b0; cpha_d = 1'b1;
        brk_d = 1'b1; vld_d = 1'b1; data_d = 8'h0F;
        step();
        brk_d = 1'b0; vld_d = 1'b0;
        wait_idle();

        // R7: settings altered mid-frame do not touch the running frame
        cpol_d = 1'b0; cpha_d = 1'b0; lc_d = 1'b0;
        send(8'hC3, 1'b0);
        repeat (20) step();
        cpol_d = 1'b1; cpha_d = 1'b1; lc_d = 1'b1;
        wait_idle();
        send(8'h3E, 1'b1);
        repeat (40) step();
        cpol_d = 1'b0; lc_d = 1'b0;
        wait_idle();
        repeat (5) step();

        done = 1;
        finish_run();
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule